// File: doc/BRIEF.md
# Scatter-Gather Sector DMA Engine

This block is the bus-master data mover that sits beside a storage device state machine. The state machine arms it with a transfer direction, a starting sector number and the total byte count of the command. It then waits for a start strobe that carries the address of a descriptor table in system memory. Once started, the engine fetches one 8-byte descriptor at a time. It cuts the memory region that the descriptor names into pieces that never cross a page boundary and moves that region one 32-bit word per beat over a simple request/acknowledge memory port. A local word-addressed buffer is the other end of each beat.

As each 512-byte sector of a region passes through, the engine reports the sector number and the command bytes still to go. After the region of the descriptor marked end-of-table, it pulses done and returns to idle. A fetch that finds the memory port busy waits a fixed back-off period and then tries again. An abort ends the job with an error pulse instead of done. If a beat is already on the bus when the abort arrives, that beat is allowed to finish first.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset `dma_state_o` is 0 (idle), no request is raised and neither `done_o` nor `err_o` is high. `arm_i` in idle gives state 1 (armed) on the next cycle. `go_i` in state 1 gives state 2 (transfer). `go_i` in idle is ignored.
- R2: The descriptor pointer is `table_base_i` with bits 1:0 forced to zero. Descriptor word 0 is read at the pointer and word 1 at pointer+4. The next descriptor is read at pointer+8.
- R3: Descriptor word 0 holds the region base address, and its bits 1:0 are ignored. In word 1, bits 15:0 are the byte count, where 0 means 65536, and bit 31 is the end-of-table flag.
- R4: Data moves as 32-bit beats at rising word addresses. `mem_last_o` marks the final beat of each chunk. A chunk is the smaller of the bytes left to the next PAGE_BYTES boundary and the bytes left in the region, so no chunk crosses a page.
- R5: With `dir_to_mem_i`=1 (disk read), the engine writes memory (`mem_we_o`=1) from the buffer. With 0 (disk write), it reads memory and writes the data into the buffer through `buf_we_o`. The buffer word index is the byte offset within the current region divided by 4.
- R6: For every 512 bytes of a region moved, `sec_done_o` pulses for one cycle. At the same time `sec_lba_o` shows that sector, numbered upward from `lba_i`, and `bytes_left_o` drops by 512.
- R7: When the last beat of the end-of-table region is acknowledged, `done_o` pulses for one cycle, `dma_state_o` returns to 0 and `bytes_left_o` is 0.
- R8: If `mem_busy_i` is high when a descriptor fetch is due, no request is made for BACKOFF_CYC cycles. After that the engine checks again.
- R9: A raised request keeps its address, write flag and last flag unchanged until `mem_ack_i`.
- R10: `abort_i` in the armed state returns the engine to idle with a one-cycle `err_o` pulse, and no request is made.
- R11: `abort_i` during a transfer raises no new request. A beat that is already raised is held until acknowledged. Then `err_o` pulses, the state returns to idle and `done_o` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm the engine for a command |
| dir_to_mem_i | input | 1 | 1: memory writes (disk read); 0: memory reads (disk write) |
| lba_i | input | 28 | First sector of the command |
| cmd_bytes_i | input | 18 | Total bytes of the command |
| go_i | input | 1 | Start strobe |
| table_base_i | input | 32 | Descriptor table address |
| abort_i | input | 1 | Abort the current job |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_last_o | output | 1 | Last beat of a chunk or of a descriptor fetch |
| mem_busy_i | input | 1 | Memory port busy, sampled before fetches |
| mem_ack_i | input | 1 | Beat accepted (read data valid) |
| mem_rdata_i | input | 32 | Read data |
| buf_addr_o | output | 14 | Buffer word index |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 32 | Buffer write data |
| buf_rdata_i | input | 32 | Buffer read data at `buf_addr_o` |
| sec_done_o | output | 1 | Sector completed pulse |
| sec_lba_o | output | 28 | Sector just completed |
| bytes_left_o | output | 18 | Command bytes still to move |
| dma_state_o | output | 2 | 0 idle, 1 armed, 2 transfer |
| done_o | output | 1 | Normal completion pulse |
| err_o | output | 1 | Abort completion pulse |

## Verification
The hardest case to reach is an abort that arrives while a data beat is raised but not yet acknowledged. In that case the engine has to keep the request steady, raise nothing after it, and finish with an error rather than done. The bench gets there in a set order. It lets a few data beats complete, withdraws acknowledge so that the beat stays pending, and asserts abort in that window. It then watches the held address for several cycles before it gives acknowledge back. The back-off path is reached in a similar way: the port is held busy across several retry periods, and the bench measures the delay from the release of busy to the first fetch.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ARMED, S_FETCH_CHK, S_BACKOFF, S_FETCH0, S_FETCH1, S_CHUNK, S_BEAT, S_DRAIN
  } eng_state_e;

  localparam logic [1:0] DMA_IDLE  = 2'd0;
  localparam logic [1:0] DMA_START = 2'd1;
  localparam logic [1:0] DMA_XFER  = 2'd2;

  localparam int unsigned SECTOR_BYTES = 512;
  localparam int unsigned DESC_BYTES   = 8;
  localparam int unsigned WORD_BYTES   = 4;

  function automatic logic [1:0] dma_phase(eng_state_e s);
    case (s)
      S_IDLE:  return DMA_IDLE;
      S_ARMED: return DMA_START;
      default: return DMA_XFER;
    endcase
  endfunction
endpackage

// File: rtl/sg_chunk_calc.sv
module sg_chunk_calc #(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned REG_W      = 17,
  localparam int unsigned PAGE_W    = $clog2(PAGE_BYTES)
) (
  input  logic [PAGE_W-1:0] addr_lo_i,
  input  logic [REG_W-1:0]  region_left_i,
  output logic [PAGE_W:0]   chunk_o
);
  logic [PAGE_W:0] to_page;
  logic            region_smaller;

  assign to_page        = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, addr_lo_i};
  assign region_smaller = region_left_i < REG_W'(to_page);
  assign chunk_o        = region_smaller ? region_left_i[PAGE_W:0] : to_page;
endmodule

// File: rtl/sg_backoff_timer.sv
module sg_backoff_timer #(
  parameter int unsigned CYC = 8,
  localparam int unsigned CNT_W = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_BO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CNT_W'(CYC - 1)));  // R8
endmodule

// File: rtl/sg_sector_track.sv
module sg_sector_track #(
  parameter int unsigned LBA_W = 28,
  parameter int unsigned CMD_W = 18,
  parameter int unsigned SEC_BYTES = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic [CMD_W-1:0] bytes_i,
  input  logic             step_i,
  output logic             sec_done_o,
  output logic [LBA_W-1:0] sec_lba_o,
  output logic [CMD_W-1:0] bytes_left_o
);
  logic [LBA_W-1:0] lba_q, sec_lba_q;
  logic [CMD_W-1:0] left_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lba_q <= '0; sec_lba_q <= '0; left_q <= '0; done_q <= 1'b0;
    end else if (load_i) begin
      lba_q <= lba_i; left_q <= bytes_i; done_q <= 1'b0;
    end else begin
      done_q <= step_i;
      if (step_i) begin
        sec_lba_q <= lba_q;
        lba_q     <= lba_q + 1'b1;
        left_q    <= left_q - CMD_W'(SEC_BYTES);
      end
    end
  end

  assign sec_done_o   = done_q;
  assign sec_lba_o    = sec_lba_q;
  assign bytes_left_o = left_q;

  AST_SEC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (lba_q == $past(lba_q) + 1'b1) && sec_done_o);  // R6
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
  import sg_dma_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 4096,
  parameter int unsigned BACKOFF_CYC = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LBA_W       = 28,
  parameter int unsigned CMD_W       = 18,
  localparam int unsigned PAGE_W     = $clog2(PAGE_BYTES),
  localparam int unsigned MAX_REGION = 2 ** CNT_W,
  localparam int unsigned REG_W      = CNT_W + 1,
  localparam int unsigned BUF_AW     = $clog2(MAX_REGION / WORD_BYTES),
  localparam int unsigned SEC_W      = $clog2(SECTOR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              dir_to_mem_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [CMD_W-1:0]  cmd_bytes_i,
  input  logic              go_i,
  input  logic [31:0]       table_base_i,
  input  logic              abort_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_last_o,
  input  logic              mem_busy_i,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [31:0]       buf_wdata_o,
  input  logic [31:0]       buf_rdata_i,
  output logic              sec_done_o,
  output logic [LBA_W-1:0]  sec_lba_o,
  output logic [CMD_W-1:0]  bytes_left_o,
  output logic [1:0]        dma_state_o,
  output logic              done_o,
  output logic              err_o
);
  eng_state_e      state_q;
  logic [31:0]     ptr_q, addr_q, drain_addr_q;
  logic [REG_W-1:0] region_left_q, off_q;
  logic [PAGE_W:0] chunk_left_q, chunk_w;
  logic            dir_q, eot_q, drain_we_q, drain_last_q;
  logic            done_q, err_q;
  logic            bo_start, bo_expired, beat_ack, sec_step, chunk_end;
  logic [CNT_W-1:0] desc_cnt;

  sg_chunk_calc #(.PAGE_BYTES(PAGE_BYTES), .REG_W(REG_W)) u_chunk (
    .addr_lo_i(addr_q[PAGE_W-1:0]), .region_left_i(region_left_q), .chunk_o(chunk_w));

  sg_backoff_timer #(.CYC(BACKOFF_CYC)) u_backoff (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(bo_start), .expired_o(bo_expired));

  sg_sector_track #(.LBA_W(LBA_W), .CMD_W(CMD_W), .SEC_BYTES(SECTOR_BYTES)) u_sector (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(state_q == S_IDLE && arm_i),
    .lba_i(lba_i), .bytes_i(cmd_bytes_i), .step_i(sec_step),
    .sec_done_o(sec_done_o), .sec_lba_o(sec_lba_o), .bytes_left_o(bytes_left_o));

  assign bo_start  = (state_q == S_FETCH_CHK) && mem_busy_i && !abort_i;
  assign beat_ack  = (state_q == S_BEAT) && mem_ack_i;
  assign sec_step  = beat_ack && (off_q[SEC_W-1:0] == SEC_W'(SECTOR_BYTES - WORD_BYTES));
  assign chunk_end = (chunk_left_q == (PAGE_W+1)'(WORD_BYTES));
  assign desc_cnt  = mem_rdata_i[CNT_W-1:0];

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    mem_last_o = 1'b0;
    case (state_q)
      S_FETCH0: begin mem_req_o = 1'b1; mem_addr_o = ptr_q; end
      S_FETCH1: begin mem_req_o = 1'b1; mem_addr_o = ptr_q + 32'd4; mem_last_o = 1'b1; end
      S_BEAT:   begin mem_req_o = 1'b1; mem_addr_o = addr_q; mem_we_o = dir_q; mem_last_o = chunk_end; end
      S_DRAIN:  begin mem_req_o = 1'b1; mem_addr_o = drain_addr_q; mem_we_o = drain_we_q; mem_last_o = drain_last_q; end
      default: ;
    endcase
  end

  assign mem_wdata_o = buf_rdata_i;
  assign buf_addr_o  = off_q[BUF_AW+1:2];
  assign buf_we_o    = beat_ack && !dir_q;
  assign buf_wdata_o = mem_rdata_i;
  assign dma_state_o = dma_phase(state_q);
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; ptr_q <= '0; addr_q <= '0; drain_addr_q <= '0;
      region_left_q <= '0; off_q <= '0; chunk_left_q <= '0;
      dir_q <= 1'b0; eot_q <= 1'b0; drain_we_q <= 1'b0; drain_last_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (arm_i) begin
          state_q <= S_ARMED;
          dir_q   <= dir_to_mem_i;
        end
        S_ARMED: begin
          if (abort_i) begin
            state_q <= S_IDLE; err_q <= 1'b1;
          end else if (go_i) begin
            ptr_q   <= {table_base_i[31:2], 2'b00};
            state_q <= S_FETCH_CHK;
          end
        end
        S_FETCH_CHK: begin
          if (abort_i) begin state_q <= S_IDLE; err_q <= 1'b1; end
          else if (mem_busy_i) state_q <= S_BACKOFF;
          else state_q <= S_FETCH0;
        end
        S_BACKOFF: begin
          if (abort_i) begin state_q <= S_IDLE; err_q <= 1'b1; end
          else if (bo_expired) state_q <= S_FETCH_CHK;
        end
        S_FETCH0: begin
          if (mem_ack_i) begin
            addr_q <= {mem_rdata_i[31:2], 2'b00};
            if (abort_i) begin state_q <= S_IDLE; err_q <= 1'b1; end
            else state_q <= S_FETCH1;
          end else if (abort_i) begin
            drain_addr_q <= ptr_q; drain_we_q <= 1'b0; drain_last_q <= 1'b0;
            state_q <= S_DRAIN;
          end
        end
        S_FETCH1: begin
          if (mem_ack_i) begin
            region_left_q <= (desc_cnt == '0) ? REG_W'(MAX_REGION) : {1'b0, desc_cnt};
            eot_q <= mem_rdata_i[31];
            ptr_q <= ptr_q + 32'(DESC_BYTES);
            off_q <= '0;
            if (abort_i) begin state_q <= S_IDLE; err_q <= 1'b1; end
            else state_q <= S_CHUNK;
          end else if (abort_i) begin
            drain_addr_q <= ptr_q + 32'd4; drain_we_q <= 1'b0; drain_last_q <= 1'b1;
            state_q <= S_DRAIN;
          end
        end
        S_CHUNK: begin
          if (abort_i) begin state_q <= S_IDLE; err_q <= 1'b1; end
          else begin
            chunk_left_q <= chunk_w;
            state_q      <= S_BEAT;
          end
        end
        S_BEAT: begin
          if (mem_ack_i) begin
            addr_q        <= addr_q + 32'(WORD_BYTES);
            chunk_left_q  <= chunk_left_q - (PAGE_W+1)'(WORD_BYTES);
            region_left_q <= region_left_q - REG_W'(WORD_BYTES);
            off_q         <= off_q + REG_W'(WORD_BYTES);
            if (abort_i) begin
              state_q <= S_IDLE; err_q <= 1'b1;
            end else if (chunk_end) begin
              if (region_left_q == REG_W'(WORD_BYTES)) begin
                if (eot_q) begin state_q <= S_IDLE; done_q <= 1'b1; end
                else state_q <= S_FETCH_CHK;
              end else state_q <= S_CHUNK;
            end
          end else if (abort_i) begin
            drain_addr_q <= addr_q; drain_we_q <= dir_q; drain_last_q <= chunk_end;
            state_q <= S_DRAIN;
          end
        end
        S_DRAIN: if (mem_ack_i) begin
          state_q <= S_IDLE; err_q <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_GO_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_state_o == DMA_IDLE) |=> (dma_state_o != DMA_XFER));  // R1
  AST_DESC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH0) |-> (mem_addr_o[1:0] == 2'b00));  // R2
  AST_NO_PAGE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BEAT && !mem_last_o) |->
      (mem_addr_o[PAGE_W-1:0] != PAGE_W'(PAGE_BYTES - WORD_BYTES)));  // R4
  AST_DONE_ZERO_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bytes_left_o == '0) && (dma_state_o == DMA_IDLE));  // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_last_o));  // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));  // R11
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);  // R11
endmodule

// File: tb/sg_dma_engine_tb_top.sv
`timescale 1ns/1ps
module sg_dma_engine_tb_top;
  localparam int BO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, dir = 0, go = 0, abort_s = 0, busy = 0, ack_en = 1;
  logic [27:0] lba = '0;
  logic [17:0] cmd_bytes = '0;
  logic [31:0] tbase = '0;
  logic mem_req, mem_we, mem_last, mem_ack, buf_we, sec_done, done, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, buf_wdata, buf_rdata;
  logic [13:0] buf_addr;
  logic [27:0] sec_lba;
  logic [17:0] bytes_left;
  logic [1:0]  dstate;

  logic [31:0] mem [2048];
  logic [31:0] bufm [2048];

  int checks = 0, failures = 0;
  int req_cnt = 0, dbeat_cnt = 0, wbeat_cnt = 0, chunk_cnt = 0, sec_cnt = 0;
  int done_cnt = 0, err_cnt = 0;
  logic [27:0] last_lba = '0;
  logic [31:0] first_addr = '0, first_last_addr = '0;
  logic got_first = 0, got_fl = 0;

  always #2 clk = ~clk;

  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = mem[mem_addr[12:2]];
  assign buf_rdata = bufm[buf_addr[10:0]];

  sg_dma_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .dir_to_mem_i(dir), .lba_i(lba),
    .cmd_bytes_i(cmd_bytes), .go_i(go), .table_base_i(tbase), .abort_i(abort_s),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_last_o(mem_last), .mem_busy_i(busy), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .buf_addr_o(buf_addr), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata),
    .sec_done_o(sec_done), .sec_lba_o(sec_lba), .bytes_left_o(bytes_left),
    .dma_state_o(dstate), .done_o(done), .err_o(err));

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[12:2]] <= mem_wdata;
    if (buf_we) bufm[buf_addr[10:0]] <= buf_wdata;
    if (rst_n) begin
      if (go) begin got_first <= 0; got_fl <= 0; end
      if (mem_req && mem_ack) begin
        req_cnt <= req_cnt + 1;
        if (!got_first) begin got_first <= 1; first_addr <= mem_addr; end
        if (mem_addr[31:8] != 24'h1) begin
          dbeat_cnt <= dbeat_cnt + 1;
          if (mem_we) wbeat_cnt <= wbeat_cnt + 1;
          if (mem_last) begin
            chunk_cnt <= chunk_cnt + 1;
            if (!got_fl) begin got_fl <= 1; first_last_addr <= mem_addr; end
          end
        end
      end
      if (sec_done) begin sec_cnt <= sec_cnt + 1; last_lba <= sec_lba; end
      if (done) done_cnt <= done_cnt + 1;
      if (err)  err_cnt <= err_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] base,
                          input logic [15:0] cnt, input logic eot);
    mem[at[12:2]]       = base;
    mem[at[12:2] + 11'd1] = {eot, 15'd0, cnt};
  endtask

  task automatic start_job(input logic d, input logic [27:0] l, input logic [17:0] b,
                           input logic [31:0] tb);
    @(negedge clk); arm = 1; dir = d; lba = l; cmd_bytes = b;
    @(negedge clk); arm = 0; go = 1; tbase = tb;
    @(negedge clk); go = 0;
  endtask

  task automatic wait_end(input int max_cyc);
    int base;
    base = done_cnt + err_cnt;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (done_cnt + err_cnt != base) break;
    end
  endtask

  task automatic t_reset;
    chk("R1 reset state", 64'(dstate), 0);
    chk("R1 reset req", 64'(mem_req), 0);
    chk("R1 reset done/err", 64'({done, err}), 0);
  endtask

  task automatic t_arm_and_start_abort;
    int r0, e0;
    r0 = req_cnt; e0 = err_cnt;
    @(negedge clk); go = 1; tbase = 32'h100;
    @(negedge clk); go = 0;
    repeat (4) @(negedge clk);
    chk("R1 go ignored in idle: state", 64'(dstate), 0);
    chk("R1 go ignored in idle: no request", 64'(req_cnt - r0), 0);
    arm = 1; @(negedge clk); arm = 0;
    chk("R1 armed state", 64'(dstate), 1);
    abort_s = 1; @(negedge clk); abort_s = 0;
    chk("R10 abort in start returns idle", 64'(dstate), 0);
    @(negedge clk);
    chk("R10 abort in start err pulse", 64'(err_cnt - e0), 1);
    chk("R10 abort in start no request", 64'(req_cnt - r0), 0);
  endtask

  task automatic t_mem_read;
    int c0, s0, d0, w0; logic ok;
    for (int i = 0; i < 256; i++) mem[(32'h400 >> 2) + i] = 32'hA500_0000 + 32'(i * 7);
    put_desc(32'h100, 32'h0000_0403, 16'd1024, 1'b1);
    c0 = chunk_cnt; s0 = sec_cnt; d0 = done_cnt; w0 = wbeat_cnt;
    start_job(1'b0, 28'd100, 18'd1024, 32'h100);
    chk("R1 transfer state", 64'(dstate), 2);
    wait_end(3000); @(negedge clk);
    ok = 1;
    for (int i = 0; i < 256; i++) if (bufm[i] !== 32'hA500_0000 + 32'(i * 7)) ok = 0;
    chk("R5 R3 buffer holds region data", 64'(ok), 1);
    chk("R5 no memory writes on disk write", 64'(wbeat_cnt - w0), 0);
    chk("R6 two sectors", 64'(sec_cnt - s0), 2);
    chk("R6 last sector number", 64'(last_lba), 101);
    chk("R4 single chunk", 64'(chunk_cnt - c0), 1);
    chk("R7 done pulse", 64'(done_cnt - d0), 1);
    chk("R7 bytes left zero", 64'(bytes_left), 0);
    chk("R7 back to idle", 64'(dstate), 0);
  endtask

  task automatic t_mem_write_sg;
    int c0, s0, d0; logic ok;
    for (int i = 0; i < 256; i++) bufm[i] = 32'hB000_0000 + 32'(i);
    put_desc(32'h100, 32'h0000_2E00, 16'd1024, 1'b0);
    put_desc(32'h108, 32'h0000_5400, 16'd512, 1'b1);
    c0 = chunk_cnt; s0 = sec_cnt; d0 = done_cnt;
    start_job(1'b1, 28'd40, 18'd1536, 32'h0000_0103);
    wait_end(4000); @(negedge clk);
    chk("R2 first fetch at masked base", 64'(first_addr), 64'h100);
    chk("R4 first chunk ends at page edge", 64'(first_last_addr), 64'h2FFC);
    chk("R4 three chunks", 64'(chunk_cnt - c0), 3);
    ok = 1;
    for (int i = 0; i < 256; i++) if (mem[(32'h0E00 >> 2) + i] !== 32'hB000_0000 + 32'(i)) ok = 0;
    chk("R5 first region written from buffer", 64'(ok), 1);
    ok = 1;
    for (int i = 0; i < 128; i++) if (mem[(32'h1400 >> 2) + i] !== 32'hB000_0000 + 32'(i)) ok = 0;
    chk("R2 second descriptor at pointer+8 moved", 64'(ok), 1);
    chk("R6 three sectors", 64'(sec_cnt - s0), 3);
    chk("R6 last sector number", 64'(last_lba), 42);
    chk("R7 done after end-of-table", 64'(done_cnt - d0), 1);
  endtask

  task automatic t_backoff;
    int r0, n, d0;
    put_desc(32'h100, 32'h0000_0C00, 16'd512, 1'b1);
    busy = 1; r0 = req_cnt; d0 = done_cnt;
    start_job(1'b0, 28'd5, 18'd512, 32'h100);
    repeat (30) @(negedge clk);
    chk("R8 no request while busy", 64'(req_cnt - r0), 0);
    busy = 0; n = 0;
    while (!mem_req && n < 40) begin @(negedge clk); n++; end
    chk("R8 fetch within backoff after release", 64'(n >= 1 && n <= BO + 2), 1);
    wait_end(3000);
    chk("R8 job completes after backoff", 64'(done_cnt - d0), 1);
  endtask

  task automatic t_abort_xfer;
    int b0, d0, e0, r0; logic [31:0] held;
    put_desc(32'h100, 32'h0000_0800, 16'd2048, 1'b1);
    b0 = dbeat_cnt; d0 = done_cnt; e0 = err_cnt;
    start_job(1'b0, 28'd0, 18'd2048, 32'h100);
    while (dbeat_cnt - b0 < 5) @(negedge clk);
    ack_en = 0;
    @(negedge clk);
    held = mem_addr;
    chk("R11 beat pending before abort", 64'(mem_req), 1);
    abort_s = 1; @(negedge clk); abort_s = 0;
    repeat (3) @(negedge clk);
    chk("R9 request held while unacknowledged", 64'(mem_req), 1);
    chk("R9 address stable while held", 64'(mem_addr), 64'(held));
    chk("R11 no err before ack", 64'(err_cnt - e0), 0);
    ack_en = 1;
    wait_end(10); @(negedge clk);
    r0 = req_cnt;
    chk("R11 err after held beat", 64'(err_cnt - e0), 1);
    chk("R11 no done on abort", 64'(done_cnt - d0), 0);
    chk("R11 idle after abort", 64'(dstate), 0);
    repeat (10) @(negedge clk);
    chk("R11 no further requests", 64'(req_cnt - r0), 0);
  endtask

  task automatic t_zero_count;
    int c0, s0, d0;
    put_desc(32'h100, 32'h0001_0000, 16'd0, 1'b1);
    c0 = chunk_cnt; s0 = sec_cnt; d0 = done_cnt;
    start_job(1'b0, 28'd7, 18'd65536, 32'h100);
    wait_end(40000); @(negedge clk);
    chk("R3 zero count moves 128 sectors", 64'(sec_cnt - s0), 128);
    chk("R4 zero count splits into 16 pages", 64'(chunk_cnt - c0), 16);
    chk("R6 last sector of 64 KiB region", 64'(last_lba), 134);
    chk("R7 done after 64 KiB region", 64'(done_cnt - d0), 1);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin mem[i] = 32'h0; bufm[i] = 32'h0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_arm_and_start_abort;
    t_mem_read;
    t_mem_write_sg;
    t_backoff;
    t_abort_xfer;
    t_zero_count;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule